// File: doc/BRIEF.md
# PCI Target Burst Read Controller

This block is the target half of a PCI interface that answers memory read bursts. It watches the shared address/data bus for the start of a transaction. When the command is a memory read and the address falls in its window, it claims the transaction with medium decode timing. It then fetches data words from a local-side source and places them on the bus, one word per data phase, for as long as the initiator keeps the burst going. The bus pins are modelled as separate input, output and output-enable signals, so the pad ring can build the shared lines.

The local side gives the captured start address and command, and sees a local frame signal that stays low for the whole transaction. The local side offers words through an active-low ready input. The block answers with an active-low transfer strobe, and each word is taken at the clock edge that ends a strobe-low cycle. The strobe follows ready with one register, and target-ready follows the strobe with one more. A local stall therefore shows up on the bus as a wait state two clocks after ready goes away. If the initiator stalls by holding initiator-ready high, the words already requested wait in a small buffer, so none is lost or sent twice. An optional upper data half serves 64-bit transfers when the initiator asks for them.

Top module: `pci_tgt_burst_rd`

## Requirements
- R1: An address cycle is a cycle where frame_ni is low and was high in the cycle before. In such a cycle, a command of 4'b0110, 4'b1100 or 4'b1110 on cbe_i[3:0] with ad_i[31:20] equal to the window base claims the transaction. In the next cycle loc_frame_no is low and loc_adr_o / loc_cmd_o show the captured address and command. Any other command or address leaves devsel_no, ctl_oe_o, loc_frame_no and loc_xfr_no high or inactive.
- R2: If the address cycle is cycle A, devsel_no is high in A+1 and low from A+2 until the final data phase completes.
- R3: ad_oe_o is low in A+1, which is the turnaround cycle, and high from A+2 while data phases remain.
- R4: If loc_rdy_ni is high in cycle N, loc_xfr_no is high in N+1. If loc_rdy_ni is low in N, no phase is stalled and the transaction is still open, loc_xfr_no is low in N+1.
- R5: A word taken from the local side at the end of cycle N is on ad_o with trdy_no low in N+1. When the initiator never stalls, trdy_no in cycle N equals loc_rdy_ni in cycle N-2, from A+2 up to the last data phase.
- R6: A data phase completes only at an edge where trdy_no and irdy_ni are both low. After a cycle with trdy_no low and irdy_ni high, ad_o is unchanged and trdy_no stays low.
- R7: Across any mix of local and initiator stalls, completed phases carry the local words in the order they were taken, with none skipped or repeated.
- R8: par_o in cycle N+1 is the XOR of ad_o and cbe_i in cycle N (even parity), and par_oe_o in N+1 equals ad_oe_o in N.
- R9: If req64_ni is low in the address cycle, ack64_no is low exactly when devsel_no is low. In that case ad_hi_o carries loc_data_i[63:32] of each word, and par64_o / par64_oe_o do the same one-clock-late parity over ad_hi_o and cbe_hi_i. Without the request, ack64_no stays high and ad_hi_oe_o stays low.
- R10: If a phase completes with frame_ni high, the next cycle drives trdy_no, devsel_no and stop_no high with ctl_oe_o high, and has ad_oe_o low and loc_frame_no high. One cycle after that, ctl_oe_o is low.
- R11: stop_no is never driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Initiator frame, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| req64_ni | input | 1 | 64-bit transfer request, active low |
| ad_i | input | DW | Address/data lines as seen on the bus |
| cbe_i | input | DW/8 | Command / byte enables, lower half |
| cbe_hi_i | input | DW/8 | Byte enables, upper half |
| ad_o | output | DW | Lower read data driven to the bus |
| ad_oe_o | output | 1 | Enable for ad_o |
| ad_hi_o | output | DW | Upper read data |
| ad_hi_oe_o | output | 1 | Enable for ad_hi_o |
| par_o | output | 1 | Parity of lower half, one clock late |
| par_oe_o | output | 1 | Enable for par_o |
| par64_o | output | 1 | Parity of upper half, one clock late |
| par64_oe_o | output | 1 | Enable for par64_o |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| stop_no | output | 1 | Stop, active low (held high) |
| ack64_no | output | 1 | 64-bit acknowledge, active low |
| ctl_oe_o | output | 1 | Enable for devsel/trdy/stop/ack64 |
| loc_frame_no | output | 1 | Local transaction frame, active low |
| loc_xfr_no | output | 1 | Local transfer strobe, active low |
| loc_rdy_ni | input | 1 | Local data ready, active low |
| loc_data_i | input | 2*DW | Local read word (upper half used for 64-bit) |
| loc_adr_o | output | DW | Captured transaction address |
| loc_cmd_o | output | 4 | Captured bus command |

## Verification
Each result has a fixed latency. The decoded address and local frame appear one cycle after the address cycle, and device-select and the data-bus enable appear two cycles after it. The transfer strobe follows local ready by one cycle and target-ready follows it by two, and parity trails its data by one. The bench sets its inputs and reads the outputs at the falling edge, so each cycle's outputs are read in that same cycle. It keeps the loc_rdy_ni, irdy_ni, ad_o and cbe_i values of the last two cycles and compares each output against the input from the right number of cycles before. Word order is checked by comparing every completed phase with the local word index recorded at the address cycle plus the count of phases already completed.

// File: rtl/pci_tbr_pkg.sv
package pci_tbr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_DATA, ST_DONE} tbr_state_e;

  localparam logic [3:0] CMD_RD      = 4'b0110;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;

  function automatic logic is_mem_read(input logic [3:0] cmd);
    return (cmd == CMD_RD) || (cmd == CMD_RD_MULT) || (cmd == CMD_RD_LINE);
  endfunction
endpackage

// File: rtl/pci_tbr_decode.sv
module pci_tbr_decode #(
  parameter int          AW       = 32,
  parameter int          WIN_LOG2 = 20,
  parameter logic [31:0] BAR_BASE = 32'h4000_0000,
  parameter bit          WIDE_EN  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          frame_ni,
  input  logic          req64_ni,
  input  logic [AW-1:0] ad_i,
  input  logic [3:0]    cmd_i,
  output logic          claim_o,
  output logic [AW-1:0] adr_o,
  output logic [3:0]    cmd_o,
  output logic          wide_o
);
  import pci_tbr_pkg::*;

  logic frame_q;
  logic addr_cyc, win_hit;

  assign addr_cyc = !frame_ni && frame_q;
  assign win_hit  = ad_i[AW-1:WIN_LOG2] == BAR_BASE[AW-1:WIN_LOG2];
  assign claim_o  = idle_i && addr_cyc && win_hit && is_mem_read(cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b1;
      adr_o   <= '0;
      cmd_o   <= '0;
      wide_o  <= 1'b0;
    end else begin
      frame_q <= frame_ni;
      if (claim_o) begin
        adr_o  <= ad_i;
        cmd_o  <= cmd_i;
        wide_o <= WIDE_EN && !req64_ni;
      end
    end
  end
endmodule

// File: rtl/pci_tbr_fifo.sv
module pci_tbr_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_o == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_o <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_o <= cnt_o + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/pci_tbr_par.sv
module pci_tbr_par #(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DW-1:0]   ad_i,
  input  logic [DW/8-1:0] be_i,
  output logic            par_o,
  output logic            par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= ^ad_i ^ ^be_i;
      par_oe_o <= en_i;
    end
  end
endmodule

// File: rtl/pci_tgt_burst_rd.sv
module pci_tgt_burst_rd #(
  parameter int          DW       = 32,
  parameter bit          WIDE_EN  = 1'b1,
  parameter int          DEPTH    = 4,
  parameter int          WIN_LOG2 = 20,
  parameter logic [31:0] BAR_BASE = 32'h4000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_ni,
  input  logic            irdy_ni,
  input  logic            req64_ni,
  input  logic [DW-1:0]   ad_i,
  input  logic [DW/8-1:0] cbe_i,
  input  logic [DW/8-1:0] cbe_hi_i,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic [DW-1:0]   ad_hi_o,
  output logic            ad_hi_oe_o,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            par64_o,
  output logic            par64_oe_o,
  output logic            devsel_no,
  output logic            trdy_no,
  output logic            stop_no,
  output logic            ack64_no,
  output logic            ctl_oe_o,
  output logic            loc_frame_no,
  output logic            loc_xfr_no,
  input  logic            loc_rdy_ni,
  input  logic [2*DW-1:0] loc_data_i,
  output logic [DW-1:0]   loc_adr_o,
  output logic [3:0]      loc_cmd_o
);
  import pci_tbr_pkg::*;

  localparam int WW  = WIDE_EN ? 2 * DW : DW;
  localparam int CAP = DEPTH + 1;            // fifo plus output stage
  localparam int CW  = $clog2(CAP + 1);

  tbr_state_e state_q, nxt;
  logic       claim, wide_q;
  logic       active, complete, last;
  logic       cap, drain, push, pop;
  logic       fifo_empty;
  logic [WW-1:0] fifo_dout, cap_word;
  logic [CW-1:0] fifo_cnt, held_d;
  logic       out_vld_q, out_vld_d;
  logic [WW-1:0] out_word_q, out_word_d;
  logic       xfr_q, devsel_q, trdy_q, ack64_q, ctl_oe_q, ad_oe_q, lframe_q;
  logic       nxt_open;

  pci_tbr_decode #(
    .AW(DW), .WIN_LOG2(WIN_LOG2), .BAR_BASE(BAR_BASE), .WIDE_EN(WIDE_EN)
  ) u_dec (
    .clk_i, .rst_ni,
    .idle_i   (state_q == ST_IDLE),
    .frame_ni,
    .req64_ni,
    .ad_i,
    .cmd_i    (cbe_i[3:0]),
    .claim_o  (claim),
    .adr_o    (loc_adr_o),
    .cmd_o    (loc_cmd_o),
    .wide_o   (wide_q)
  );

  assign active   = (state_q == ST_TURN) || (state_q == ST_DATA);
  assign complete = (state_q == ST_DATA) && !trdy_q && !irdy_ni;
  assign last     = complete && frame_ni;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (claim) nxt = ST_TURN;
      ST_TURN: nxt = ST_DATA;
      ST_DATA: if (last) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign nxt_open = (nxt == ST_TURN) || (nxt == ST_DATA);

  // local word capture and output staging with fifo bypass
  assign cap      = active && !xfr_q;
  assign cap_word = loc_data_i[WW-1:0];
  assign drain    = !out_vld_q || complete;
  assign pop      = drain && !fifo_empty && !last;
  assign push     = cap && !(drain && fifo_empty) && !last;

  always_comb begin
    out_vld_d  = last ? 1'b0 : ((out_vld_q && !complete) || !fifo_empty || cap);
    out_word_d = out_word_q;
    if (drain) out_word_d = fifo_empty ? cap_word : fifo_dout;
  end

  pci_tbr_fifo #(.W(WW), .DEPTH(DEPTH), .CNT_W(CW)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (last),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (cap_word),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  // words held after this edge; a strobe next cycle may add one more
  assign held_d = last ? '0 : (fifo_cnt + CW'(push) - CW'(pop) + CW'(out_vld_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      out_vld_q  <= 1'b0;
      out_word_q <= '0;
      xfr_q      <= 1'b1;
      devsel_q   <= 1'b1;
      trdy_q     <= 1'b1;
      ack64_q    <= 1'b1;
      ctl_oe_q   <= 1'b0;
      ad_oe_q    <= 1'b0;
      lframe_q   <= 1'b1;
    end else begin
      state_q    <= nxt;
      out_vld_q  <= out_vld_d;
      out_word_q <= out_word_d;
      xfr_q      <= !(nxt_open && !loc_rdy_ni && (held_d < CW'(CAP)));
      devsel_q   <= !(nxt == ST_DATA);
      trdy_q     <= !((nxt == ST_DATA) && out_vld_d);
      ack64_q    <= !((nxt == ST_DATA) && wide_q);
      ctl_oe_q   <= (nxt == ST_DATA) || (nxt == ST_DONE);
      ad_oe_q    <= (nxt == ST_DATA);
      lframe_q   <= !nxt_open;
    end
  end

  assign ad_o         = out_word_q[DW-1:0];
  assign ad_oe_o      = ad_oe_q;
  assign devsel_no    = devsel_q;
  assign trdy_no      = trdy_q;
  assign stop_no      = 1'b1;
  assign ack64_no     = ack64_q;
  assign ctl_oe_o     = ctl_oe_q;
  assign loc_frame_no = lframe_q;
  assign loc_xfr_no   = xfr_q;

  pci_tbr_par #(.DW(DW)) u_par_lo (
    .clk_i, .rst_ni,
    .en_i     (ad_oe_q),
    .ad_i     (ad_o),
    .be_i     (cbe_i),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  if (WIDE_EN) begin : g_wide
    assign ad_hi_o    = out_word_q[WW-1:DW];
    assign ad_hi_oe_o = ad_oe_q && wide_q;
    pci_tbr_par #(.DW(DW)) u_par_hi (
      .clk_i, .rst_ni,
      .en_i     (ad_hi_oe_o),
      .ad_i     (ad_hi_o),
      .be_i     (cbe_hi_i),
      .par_o    (par64_o),
      .par_oe_o (par64_oe_o)
    );
  end else begin : g_narrow
    assign ad_hi_o    = '0;
    assign ad_hi_oe_o = 1'b0;
    assign par64_o    = 1'b0;
    assign par64_oe_o = 1'b0;
  end
endmodule

// File: rtl/pci_tgt_burst_rd_chk.sv
module pci_tgt_burst_rd_chk #(
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_ni,
  input logic            irdy_ni,
  input logic            loc_rdy_ni,
  input logic            loc_xfr_no,
  input logic            loc_frame_no,
  input logic            trdy_no,
  input logic            devsel_no,
  input logic            ack64_no,
  input logic            ctl_oe_o,
  input logic            ad_oe_o,
  input logic [DW-1:0]   ad_o,
  input logic [DW/8-1:0] cbe_i,
  input logic            par_o,
  input logic            par_oe_o
);
  // R1
  strobe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_xfr_no |-> !loc_frame_no);

  // R2
  devsel_after_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |-> ($past(!loc_frame_no) && $past(!ad_oe_o)));

  // R4
  xfr_follows_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_rdy_ni |=> loc_xfr_no);

  // R5
  trdy_needs_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> (!devsel_no && ad_oe_o && ctl_oe_o));

  // R6
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> (!trdy_no && $stable(ad_o)));

  // R8
  par_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |=> (par_oe_o && (par_o == (^$past(ad_o) ^ ^$past(cbe_i)))));

  // R9
  ack64_with_devsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack64_no |-> !devsel_no);

  // R10
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni && frame_ni) |=>
      (trdy_no && devsel_no && ctl_oe_o && !ad_oe_o && loc_frame_no));
endmodule

bind pci_tgt_burst_rd pci_tgt_burst_rd_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_ni     (frame_ni),
  .irdy_ni      (irdy_ni),
  .loc_rdy_ni   (loc_rdy_ni),
  .loc_xfr_no   (loc_xfr_no),
  .loc_frame_no (loc_frame_no),
  .trdy_no      (trdy_no),
  .devsel_no    (devsel_no),
  .ack64_no     (ack64_no),
  .ctl_oe_o     (ctl_oe_o),
  .ad_oe_o      (ad_oe_o),
  .ad_o         (ad_o),
  .cbe_i        (cbe_i),
  .par_o        (par_o),
  .par_oe_o     (par_oe_o)
);

// File: tb/pci_tgt_burst_rd_tb.sv
module pci_tgt_burst_rd_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h4000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1, irdy_ni = 1'b1, req64_ni = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0, cbe_hi_i = '0;
  logic [31:0] ad_o, ad_hi_o, loc_adr_o;
  logic        ad_oe_o, ad_hi_oe_o, par_o, par_oe_o, par64_o, par64_oe_o;
  logic        devsel_no, trdy_no, stop_no, ack64_no, ctl_oe_o;
  logic        loc_frame_no, loc_xfr_no;
  logic        loc_rdy_ni = 1'b1;
  logic [63:0] loc_data_i;
  logic [3:0]  loc_cmd_o;
  logic [31:0] idx = '0;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] mk_lo(input logic [31:0] i);
    return 32'hC300_0000 + i;
  endfunction
  function automatic logic [31:0] mk_hi(input logic [31:0] i);
    return 32'h5A00_0000 + i * 32'd3;
  endfunction

  // local source: word idx is offered while the strobe is low
  assign loc_data_i = {mk_hi(idx), mk_lo(idx)};
  always @(posedge clk_i) if (!loc_xfr_no) idx <= idx + 1;

  pci_tgt_burst_rd u_dut (
    .clk_i, .rst_ni, .frame_ni, .irdy_ni, .req64_ni, .ad_i, .cbe_i, .cbe_hi_i,
    .ad_o, .ad_oe_o, .ad_hi_o, .ad_hi_oe_o, .par_o, .par_oe_o, .par64_o, .par64_oe_o,
    .devsel_no, .trdy_no, .stop_no, .ack64_no, .ctl_oe_o,
    .loc_frame_no, .loc_xfr_no, .loc_rdy_ni, .loc_data_i, .loc_adr_o, .loc_cmd_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    check("R2 reset devsel", 64'(devsel_no), 64'd1);
    check("R5 reset trdy", 64'(trdy_no), 64'd1);
    check("R10 reset ctl_oe", 64'(ctl_oe_o), 64'd0);
    check("R3 reset ad_oe", 64'(ad_oe_o), 64'd0);
    check("R1 reset loc_frame", 64'(loc_frame_no), 64'd1);
    check("R4 reset loc_xfr", 64'(loc_xfr_no), 64'd1);
    check("R9 reset ack64", 64'(ack64_no), 64'd1);
    check("R11 reset stop", 64'(stop_no), 64'd1);
  endtask

  // Generic read burst. Bit r of a mask applies to cycle r (r=0 is the address cycle).
  task automatic t_burst(input string name, input logic [31:0] addr, input logic [3:0] cmd,
                         input int n, input bit wide,
                         input logic [63:0] rdy_mask, input logic [63:0] irdy_mask);
    logic [31:0] base, prev_ad;
    logic        prev_trdy, prev_irdy, prev_oe, prev_hi_oe, pexp, pexp64;
    bit          strict;
    int          k;
    strict = (irdy_mask == '0);
    @(negedge clk_i);
    base = idx;
    frame_ni = 1'b0; irdy_ni = 1'b1; ad_i = addr; cbe_i = cmd;
    req64_ni = !wide; loc_rdy_ni = rdy_mask[0];
    k = 0; prev_trdy = 1'b1; prev_irdy = 1'b1; prev_oe = 1'b0; prev_hi_oe = 1'b0;
    pexp = 1'b0; pexp64 = 1'b0; prev_ad = '0;
    for (int r = 1; r < 60; r++) begin
      @(negedge clk_i);
      if (r == 1) begin
        check({name, " R1 loc_frame"}, 64'(loc_frame_no), 64'd0);
        check({name, " R1 loc_adr"}, 64'(loc_adr_o), 64'(addr));
        check({name, " R1 loc_cmd"}, 64'(loc_cmd_o), 64'(cmd));
        check({name, " R3 turnaround ad_oe"}, 64'(ad_oe_o), 64'd0);
        check({name, " R2 devsel in turnaround"}, 64'(devsel_no), 64'd1);
      end
      if (r == 2) begin
        check({name, " R2 devsel medium"}, 64'(devsel_no), 64'd0);
        check({name, " R3 ad_oe"}, 64'(ad_oe_o), 64'd1);
        check({name, " R9 ack64"}, 64'(ack64_no), 64'(!wide));
        check({name, " R9 ad_hi_oe"}, 64'(ad_hi_oe_o), 64'(wide));
        check({name, " R11 stop"}, 64'(stop_no), 64'd1);
      end
      if (rdy_mask[r-1])
        check({name, " R4 strobe off after ready high"}, 64'(loc_xfr_no), 64'd1);
      else if (strict)
        check({name, " R4 strobe on after ready low"}, 64'(loc_xfr_no), 64'd0);
      if (strict && r >= 2)
        check({name, " R5 trdy two cycles after ready"}, 64'(trdy_no), 64'(rdy_mask[r-2]));
      if (prev_oe)
        check({name, " R8 parity"}, 64'(par_o), 64'(pexp));
      check({name, " R8 par_oe"}, 64'(par_oe_o), 64'(prev_oe));
      if (prev_hi_oe)
        check({name, " R9 par64"}, 64'(par64_o), 64'(pexp64));
      if (!prev_trdy && prev_irdy) begin
        check({name, " R6 hold data"}, 64'(ad_o), 64'(prev_ad));
        check({name, " R6 hold trdy"}, 64'(trdy_no), 64'd0);
      end
      // inputs for cycle r
      ad_i = '0; cbe_i = 4'(r); cbe_hi_i = ~4'(r); loc_rdy_ni = rdy_mask[r];
      irdy_ni = frame_ni ? 1'b0 : irdy_mask[r];
      if (!frame_ni && !irdy_ni && k == n - 1) frame_ni = 1'b1;
      if (!trdy_no && !irdy_ni) begin
        check({name, " R7 word order lo"}, 64'(ad_o), 64'(mk_lo(base + 32'(k))));
        if (wide) check({name, " R9 word hi"}, 64'(ad_hi_o), 64'(mk_hi(base + 32'(k))));
        k++;
      end
      prev_ad = ad_o; prev_trdy = trdy_no; prev_irdy = irdy_ni;
      prev_oe = ad_oe_o; prev_hi_oe = ad_hi_oe_o;
      pexp = ^ad_o ^ ^cbe_i; pexp64 = ^ad_hi_o ^ ^cbe_hi_i;
      if (k == n) break;
    end
    check({name, " R7 phase count"}, 64'(k), 64'(n));
    @(negedge clk_i);
    check({name, " R10 trdy released"}, 64'(trdy_no), 64'd1);
    check({name, " R10 devsel released"}, 64'(devsel_no), 64'd1);
    check({name, " R10 stop high"}, 64'(stop_no), 64'd1);
    check({name, " R10 ctl_oe held"}, 64'(ctl_oe_o), 64'd1);
    check({name, " R10 ad_oe off"}, 64'(ad_oe_o), 64'd0);
    check({name, " R10 loc_frame off"}, 64'(loc_frame_no), 64'd1);
    check({name, " R8 last parity"}, 64'(par_o), 64'(pexp));
    check({name, " R9 ack64 off"}, 64'(ack64_no), 64'd1);
    irdy_ni = 1'b1; req64_ni = 1'b1; loc_rdy_ni = 1'b1; cbe_i = '0; cbe_hi_i = '0;
    @(negedge clk_i);
    check({name, " R10 ctl_oe floats"}, 64'(ctl_oe_o), 64'd0);
    check({name, " R8 par_oe off"}, 64'(par_oe_o), 64'd0);
  endtask

  task automatic t_ignore(input string name, input logic [31:0] addr, input logic [3:0] cmd);
    @(negedge clk_i);
    frame_ni = 1'b0; irdy_ni = 1'b1; ad_i = addr; cbe_i = cmd; loc_rdy_ni = 1'b0;
    @(negedge clk_i);
    frame_ni = 1'b1; irdy_ni = 1'b0; ad_i = '0; cbe_i = '0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      check({name, " R1 no devsel"}, 64'(devsel_no), 64'd1);
      check({name, " R1 no ctl_oe"}, 64'(ctl_oe_o), 64'd0);
      check({name, " R1 no loc_frame"}, 64'(loc_frame_no), 64'd1);
      check({name, " R1 no strobe"}, 64'(loc_xfr_no), 64'd1);
      irdy_ni = 1'b1;
    end
    loc_rdy_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_burst("basic32", WIN + 32'h100, 4'b0110, 4, 1'b0, 64'h0, 64'h0);
    t_burst("local_wait", WIN + 32'h200, 4'b1100, 6, 1'b0, 64'h0000_0000_0000_0048, 64'h0);
    t_burst("init_stall", WIN + 32'h300, 4'b1110, 9, 1'b0, 64'h0, 64'h0000_0000_0000_03F8);
    t_burst("mixed", WIN + 32'h400, 4'b0110, 10, 1'b1, 64'h0000_0000_0000_0A24,
            64'h0000_0000_0000_4190);
    t_burst("wide64", WIN + 32'h500, 4'b1100, 5, 1'b1, 64'h0000_0000_0000_0010, 64'h0);
    t_burst("single", WIN + 32'h600, 4'b0110, 1, 1'b0, 64'h0, 64'h0);
    t_burst("late_start", WIN + 32'h700, 4'b1110, 3, 1'b0, 64'h0000_0000_0000_0007, 64'h0);
    t_ignore("write_cmd", WIN + 32'h10, 4'b0111);
    t_ignore("out_of_window", 32'h8000_0000, 4'b0110);
    t_burst("after_ignore", WIN + 32'h20, 4'b0110, 2, 1'b0, 64'h0, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule